// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synchronous static memory with a word built from two 9-bit byte lanes. Every control input and the address are captured on the rising clock edge. A read returns its word through an output register, so the data is on the bus in the cycle that follows the sampling edge. A write takes its address and lane enables at one edge and its data at the next edge (late write).

The captured write is held in a pending buffer until the next write is issued, and only then is it stored in the array. A read that hits the pending address gets the pending lanes merged over the array word. The bus is modelled as separate input, output and drive-enable signals. The drive enable also depends on an asynchronous output enable and a sleep input.

Control is split between two state machines. The bus machine has the states BUS_IDLE, BUS_READ, BUS_WRITE and BUS_SLEEP. Every edge moves it to the state that the sampled inputs select:
- sleep high gives BUS_SLEEP;
- otherwise, chip select inactive gives BUS_IDLE;
- otherwise, write enable high gives BUS_READ;
- otherwise, BUS_WRITE.

The pending machine has the states PND_EMPTY, PND_WAIT and PND_HELD. An issued write moves it from any state to PND_WAIT. PND_WAIT goes to PND_HELD at the next edge, when the data is captured. PND_HELD stays put until the next write. Reset enters BUS_IDLE and PND_EMPTY.

Top module: `lw_sram`

## Requirements
- R1: With chip select low, write enable high and sleep low at an edge, the word at the address is driven on dq_out during the following cycle, with dq_oe high while oe_n is low.
- R2: A write issued at edge k leaves dq_oe low in the cycle after edge k. The value on dq_in at edge k+1 is the data written.
- R3: bw_n[0] low enables lane A (bits 8:0) and bw_n[1] low enables lane B (bits 17:9). A lane whose enable is high keeps its old content, and a write with both enables high changes nothing.
- R4: An edge with cs_n high performs no access, changes no stored data and leaves dq_oe low in the following cycle.
- R5: oe_n high forces dq_oe low at once, without a clock. A read sampled while oe_n is high still loads its word, which appears when oe_n falls within that cycle.
- R6: An edge with zz high performs no new operation, and dq_oe is low for as long as zz is high. Write data already due at that edge is still captured.
- R7: A read of the address of a write not yet stored in the array returns the pending data on the enabled lanes and the array content on the others. This includes a read issued at the edge where that write's data is captured.
- R8: A pending write is stored when the next write is issued. Back-to-back writes, to the same or to different addresses, all take effect.
- R9: While reset is asserted and after it is released, dq_oe and dq_out are zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, sampled |
| we_n | input | 1 | Write enable, active low, sampled |
| bw_n | input | LANES | Lane write enables, active low, sampled |
| addr | input | ADDR_W | Word address, sampled |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep, active high |
| dq_in | input | LANES*LANE_W | Bus value seen by the memory |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is a read that arrives while the pending write is still in PND_WAIT. In that cycle the data being forwarded is on dq_in at the same edge, not yet in any register, and it must be merged lane by lane with the array word. The bench reaches this case by issuing a read right after each write, for every address and for all four lane-enable patterns. It repeats the read after an idle cycle to cover PND_HELD, and again after a second write to cover the stored result. A long pseudo-random mix of reads, writes, deselects, sleeps and dummy reads then produces the rarer mixtures, such as a sleep edge that lands while write data is due.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2,
        BUS_SLEEP = 2'd3
    } bus_st_e;

    typedef enum logic [1:0] {
        PND_EMPTY = 2'd0,
        PND_WAIT  = 2'd1,
        PND_HELD  = 2'd2
    } pend_st_e;

endpackage

// File: rtl/lw_cmd_fsm.sv
`timescale 1ns/1ps
module lw_cmd_fsm
    import lw_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    input  logic zz,
    output logic rd_go,
    output logic wr_go,
    output logic drive
);

    bus_st_e bus_st;
    bus_st_e bus_nxt;

    // Next state: the sampled inputs pick the operation of this edge.
    always_comb begin
        if (zz) begin
            bus_nxt = BUS_SLEEP;
        end else if (cs_n) begin
            bus_nxt = BUS_IDLE;
        end else if (we_n) begin
            bus_nxt = BUS_READ;
        end else begin
            bus_nxt = BUS_WRITE;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_st <= BUS_IDLE;
        end else begin
            bus_st <= bus_nxt;
        end
    end

    // Outputs: edge strobes from the next state, bus drive from the current state.
    always_comb begin
        rd_go = 1'b0;
        wr_go = 1'b0;
        unique case (bus_nxt)
            BUS_READ:  rd_go = 1'b1;
            BUS_WRITE: wr_go = 1'b1;
            BUS_IDLE, BUS_SLEEP: ;
            default: ;
        endcase
        drive = 1'b0;
        unique case (bus_st)
            BUS_READ: drive = 1'b1;
            BUS_IDLE, BUS_WRITE, BUS_SLEEP: drive = 1'b0;
            default: drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/lw_pend_buf.sv
`timescale 1ns/1ps
module lw_pend_buf
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_go,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES-1:0]          wr_bw_n,
    input  logic [LANES*LANE_W-1:0]   dq_in,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic                      commit_en,
    output logic [ADDR_W-1:0]         commit_addr,
    output logic [LANES-1:0]          commit_lanes,
    output logic [LANES*LANE_W-1:0]   commit_data,
    output logic                      fwd_hit,
    output logic [LANES-1:0]          fwd_lanes,
    output logic [LANES*LANE_W-1:0]   fwd_data
);

    localparam int DATA_W = LANES * LANE_W;

    pend_st_e              pst;
    pend_st_e              pnxt;
    logic [ADDR_W-1:0]     p_addr;
    logic [LANES-1:0]      p_bw_n;
    logic [DATA_W-1:0]     p_data;
    logic [DATA_W-1:0]     live_data;

    // While data is due, the bus value at this edge is the pending word.
    assign live_data = (pst == PND_WAIT) ? dq_in : p_data;

    always_comb begin
        pnxt = pst;
        unique case (pst)
            PND_EMPTY: pnxt = wr_go ? PND_WAIT : PND_EMPTY;
            PND_WAIT:  pnxt = wr_go ? PND_WAIT : PND_HELD;
            PND_HELD:  pnxt = wr_go ? PND_WAIT : PND_HELD;
            default:   pnxt = PND_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pst <= PND_EMPTY;
        end else begin
            pst <= pnxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_addr <= '0;
            p_bw_n <= '1;
            p_data <= '0;
        end else begin
            if (pst == PND_WAIT) begin
                p_data <= dq_in;
            end
            if (wr_go) begin
                p_addr <= wr_addr;
                p_bw_n <= wr_bw_n;
            end
        end
    end

    // Outputs: store the old pending word at a new write, forward on a match.
    always_comb begin
        commit_en    = 1'b0;
        fwd_hit      = 1'b0;
        unique case (pst)
            PND_EMPTY: begin
                commit_en = 1'b0;
                fwd_hit   = 1'b0;
            end
            PND_WAIT, PND_HELD: begin
                commit_en = wr_go;
                fwd_hit   = (p_addr == rd_addr);
            end
            default: ;
        endcase
        commit_addr  = p_addr;
        commit_lanes = ~p_bw_n;
        commit_data  = live_data;
        fwd_lanes    = ~p_bw_n;
        fwd_data     = live_data;
    end

endmodule

// File: rtl/lw_store.sv
`timescale 1ns/1ps
module lw_store #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          wr_lanes,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[l]) begin
                cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      we_n,
    input  logic [LANES-1:0]          bw_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      oe_n,
    input  logic                      zz,
    input  logic [LANES*LANE_W-1:0]   dq_in,
    output logic [LANES*LANE_W-1:0]   dq_out,
    output logic                      dq_oe
);

    localparam int DATA_W = LANES * LANE_W;

    logic                 rd_go;
    logic                 wr_go;
    logic                 drive;
    logic                 commit_en;
    logic [ADDR_W-1:0]    commit_addr;
    logic [LANES-1:0]     commit_lanes;
    logic [DATA_W-1:0]    commit_data;
    logic                 fwd_hit;
    logic [LANES-1:0]     fwd_lanes;
    logic [DATA_W-1:0]    fwd_data;
    logic [DATA_W-1:0]    arr_data;
    logic [DATA_W-1:0]    rd_word;
    logic [DATA_W-1:0]    q_r;

    lw_cmd_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .we_n  (we_n),
        .zz    (zz),
        .rd_go (rd_go),
        .wr_go (wr_go),
        .drive (drive)
    );

    lw_pend_buf #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_go        (wr_go),
        .wr_addr      (addr),
        .wr_bw_n      (bw_n),
        .dq_in        (dq_in),
        .rd_addr      (addr),
        .commit_en    (commit_en),
        .commit_addr  (commit_addr),
        .commit_lanes (commit_lanes),
        .commit_data  (commit_data),
        .fwd_hit      (fwd_hit),
        .fwd_lanes    (fwd_lanes),
        .fwd_data     (fwd_data)
    );

    lw_store #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_store (
        .clk      (clk),
        .wr_en    (commit_en),
        .wr_lanes (commit_lanes),
        .wr_addr  (commit_addr),
        .wr_data  (commit_data),
        .rd_addr  (addr),
        .rd_data  (arr_data)
    );

    // Per-lane merge of pending data over the array word.
    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign rd_word[l*LANE_W +: LANE_W] = (fwd_hit && fwd_lanes[l])
                                           ? fwd_data[l*LANE_W +: LANE_W]
                                           : arr_data[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (rd_go) begin
            q_r <= rd_word;
        end
    end

    assign dq_out = q_r;
    assign dq_oe  = drive & ~oe_n & ~zz;

endmodule

// File: rtl/lw_sram_chk.sv
`timescale 1ns/1ps
module lw_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic we_n,
    input logic oe_n,
    input logic zz,
    input logic dq_oe
);

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !zz) |=> (dq_oe == (!oe_n && !zz))); // R1

    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n && !zz) |=> !dq_oe); // R2

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !zz) |=> !dq_oe); // R4

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R5

    AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        zz |-> !dq_oe); // R6

    AST_SLEEP_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        zz |=> !dq_oe); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !dq_oe); // R9

endmodule

bind lw_sram lw_sram_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .zz    (zz),
    .dq_oe (dq_oe)
);

// File: tb/sim_lw_sram.sv
`timescale 1ns/1ps
module sim_lw_sram;

    localparam int AW    = 4;
    localparam int DW    = 18;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n, we_n, oe_n, zz;
    logic [1:0]    bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #2 clk = ~clk;

    lw_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .bw_n(bw_n),
        .addr(addr), .oe_n(oe_n), .zz(zz), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    logic [DW-1:0] ref_mem [DEPTH];
    int            n_run  = 0;
    int            n_fail = 0;
    bit            due    = 1'b0;
    logic [AW-1:0] due_a;
    logic [1:0]    due_bw;
    logic [DW-1:0] due_d;
    logic [31:0]   lfsr   = 32'h1234_5679;

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                             logic [1:0] bw);
        logic [DW-1:0] r;
        r[8:0]  = bw[0] ? old_w[8:0]  : new_w[8:0];
        r[17:9] = bw[1] ? old_w[17:9] : new_w[17:9];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(int a, int salt);
        logic [31:0] v;
        v = (a * 32'h9E37) ^ (salt * 32'h3B1) ^ 32'h15A5A;
        return v[DW-1:0];
    endfunction

    task automatic step_lfsr();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
    endtask

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation per clock edge; the bus carries due write data.
    task automatic op(logic c, logic w, logic [1:0] bw, logic [AW-1:0] a,
                      logic [DW-1:0] d, logic o, logic z, bit peek, string req);
        bit            is_rd, is_wr;
        logic [DW-1:0] exp;
        @(negedge clk);
        step_lfsr();
        cs_n = c; we_n = w; bw_n = bw; addr = a; oe_n = o; zz = z;
        dq_in = due ? due_d : lfsr[DW-1:0];
        @(posedge clk);
        if (due) begin
            ref_mem[due_a] = merge(ref_mem[due_a], due_d, due_bw);
            due = 1'b0;
        end
        is_rd = !z && !c && w;
        is_wr = !z && !c && !w;
        if (is_wr) begin
            due = 1'b1; due_a = a; due_bw = bw; due_d = d;
        end
        exp = is_rd ? ref_mem[a] : '0;
        #1;
        if (is_rd && !o) begin
            chk({req, " oe"}, {17'b0, dq_oe}, 18'd1);
            chk({req, " data"}, dq_out, exp);
        end else begin
            chk({req, " hiz"}, {17'b0, dq_oe}, 18'd0);
            if (is_rd && peek) begin
                oe_n = 1'b0;
                #0.5;
                chk("R5 late oe", {17'b0, dq_oe}, 18'd1);
                chk("R5 dummy data", dq_out, exp);
            end
        end
    endtask

    task automatic wr(int a, logic [DW-1:0] d, logic [1:0] bw, string req);
        op(1'b0, 1'b0, bw, a[AW-1:0], d, 1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic rd(int a, string req);
        op(1'b0, 1'b1, 2'b11, a[AW-1:0], '0, 1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic idle(string req);
        op(1'b1, 1'b1, 2'b11, '0, '0, 1'b0, 1'b0, 1'b0, req);
    endtask

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog all-reqs actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; bw_n = 2'b11; addr = '0;
        oe_n = 1'b0; zz = 1'b0; dq_in = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 oe in reset", {17'b0, dq_oe}, 18'd0);
        chk("R9 dout in reset", dq_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 oe after reset", {17'b0, dq_oe}, 18'd0);
        chk("R9 dout after reset", dq_out, '0);

        // R8: fill with back-to-back writes, then read everything back (R1).
        for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 1), 2'b00, "R8 fill");
        idle("R4 gap");
        for (int a = 0; a < DEPTH; a++) rd(a, "R1 read");

        // R3/R7: every lane pattern, immediate and held forwarding, then stored.
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 0; b < 4; b++) begin
                wr(a, pat(a, 10 + b), b[1:0], "R3 lane write");
                rd(a, "R7 fwd wait");
                idle("R4 idle");
                rd(a, "R7 fwd held");
                wr((a + 1) % DEPTH, pat(a, 20 + b), 2'b00, "R8 next write");
                rd(a, "R8 stored");
            end
        end

        // R8: same address twice in a row, different lanes.
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, pat(a, 30), 2'b10, "R8 same1");
            wr(a, pat(a, 31), 2'b01, "R8 same2");
            rd(a, "R8 same fwd");
            wr((a + 3) % DEPTH, pat(a, 32), 2'b00, "R8 flush");
            rd(a, "R8 same stored");
        end

        // R4: deselected write attempts change nothing.
        for (int a = 0; a < DEPTH; a++) begin
            op(1'b1, 1'b0, 2'b00, a[AW-1:0], pat(a, 40), 1'b0, 1'b0, 1'b0, "R4 desel");
            rd(a, "R4 unchanged");
        end

        // R6: sleep edges ignore writes; due data is still captured.
        for (int a = 0; a < DEPTH; a++) begin
            op(1'b0, 1'b0, 2'b00, a[AW-1:0], pat(a, 50), 1'b0, 1'b1, 1'b0, "R6 sleep write");
            rd(a, "R6 unchanged");
            wr(a, pat(a, 51), 2'b00, "R2 write");
            op(1'b0, 1'b1, 2'b11, a[AW-1:0], '0, 1'b0, 1'b1, 1'b0, "R6 sleep due");
            rd(a, "R6 due kept");
        end

        // R5: dummy reads, released within the cycle.
        for (int a = 0; a < DEPTH; a++) begin
            op(1'b0, 1'b1, 2'b11, a[AW-1:0], '0, 1'b1, 1'b0, 1'b1, "R5 dummy");
        end

        // Pseudo-random mix over all requirements.
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]    sel;
            logic [AW-1:0] ra;
            logic [1:0]    rb;
            logic          ro;
            step_lfsr();
            sel = lfsr[2:0];
            ra  = lfsr[3 +: AW];
            rb  = lfsr[9:8];
            ro  = (lfsr[12:10] == 3'd0);
            step_lfsr();
            case (sel)
                3'd0, 3'd1, 3'd2, 3'd3:
                    op(1'b0, 1'b1, 2'b11, ra, '0, ro, 1'b0, 1'b1, "R1 mix read");
                3'd4, 3'd5:
                    op(1'b0, 1'b0, rb, ra, lfsr[DW-1:0], ro, 1'b0, 1'b0, "R2 mix write");
                3'd6:
                    op(1'b1, lfsr[20], rb, ra, '0, ro, 1'b0, 1'b0, "R4 mix desel");
                default:
                    op(1'b0, lfsr[20], rb, ra, '0, ro, 1'b1, 1'b0, "R6 mix sleep");
            endcase
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule